// File: doc/BRIEF.md
# Load-Use Stall Cycle Accounting Unit

This block sits beside a single-issue pipeline model and prices every retired instruction in cycles. With each instruction it is told which execution unit handled it, the unit's base cost, up to two source register indices with valid flags, the destination of a load, and for branches whether the branch was taken and whether it has a delay slot. It returns the cycle cost of that instruction one clock later and keeps five running totals: all cycles, cycles lost to load-use hazards, cycles lost to taken branches, and the number of taken and not-taken branches.

Load-use hazards are tracked with a scoreboard that looks back exactly one instruction. A load marks its destination register. The next instruction pays one extra cycle for each checked source operand that reads a marked register. A taken branch without a delay slot pays one extra cycle. Multi-register transfers are charged their base cost only. Decoding and execution happen elsewhere; this unit only counts.

Top module: `cyc_acct_top`

## Requirements
- R1: While reset is asserted, and after it until the first instruction, every output is zero.
- R2: The unit code is 0 exec, 1 branch, 2 load, 3 store, 4 load-multiple, 5 store-multiple; codes 6 and 7 are charged like the multi-register kinds.
- R3: For exec and store, source A and source B are each checked. Each valid source whose register is marked by the previous instruction adds one cycle and one load stall. Naming the same register twice costs two.
- R4: For load and branch, only source A is checked. Source B has no effect on cost or counters.
- R5: A source whose valid flag is low never causes a stall.
- R6: The mark set is rebuilt on every instruction strobe. A load marks only its own destination, and any other kind leaves nothing marked. Idle clocks between two instructions do not change it.
- R7: A taken branch without a delay slot adds one cycle and one branch stall. A taken branch with a delay slot, or a branch that is not taken, adds none.
- R8: Every branch increments exactly one of the taken and not-taken counters, chosen by its taken flag.
- R9: Kinds 4 to 7 are charged exactly their base cost, ignore both sources, and leave no register marked.
- R10: The clock after an instruction strobe, `insn_cycles` shows base plus stalls, `insn_done` is high for that single clock, and `total_cycles` has grown by the same amount.
- R11: Every counter saturates at its all-ones value and then holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | One-clock strobe: an instruction retires |
| unit_kind | input | 3 | Unit code (see R2) |
| base_cycles | input | BASE_W (8) | Base cost of the instruction |
| src_a_idx | input | 4 | First source register |
| src_a_vld | input | 1 | First source is used |
| src_b_idx | input | 4 | Second source register |
| src_b_vld | input | 1 | Second source is used |
| load_dst | input | 4 | Destination register of a load |
| br_taken | input | 1 | Branch was taken |
| br_has_slot | input | 1 | Branch has a delay slot |
| insn_cycles | output | BASE_W+2 (10) | Cost of the last instruction |
| insn_done | output | 1 | insn_cycles was updated this clock |
| total_cycles | output | COUNT_W (32) | Saturating sum of instruction costs |
| load_stall_cnt | output | COUNT_W (32) | Saturating load-use stall cycles |
| branch_stall_cnt | output | COUNT_W (32) | Saturating taken-branch stall cycles |
| taken_cnt | output | COUNT_W (32) | Saturating taken branches |
| untaken_cnt | output | COUNT_W (32) | Saturating not-taken branches |

## Verification
Load-then-consumer pairs are sent for every unit kind, with the hazard register placed on source A, on source B, on both, and on neither. These separate the per-kind operand selection and the invalid-flag gating. Gaps of idle clocks and intervening non-load instructions between producer and consumer show whether the scoreboard window follows instructions rather than clocks. Branches are sent with all four combinations of taken and delay slot. A narrowed counter width drives the totals into saturation.

// File: rtl/cyc_acct_pkg.sv
package cyc_acct_pkg;
  typedef enum logic [2:0] {
    U_EXEC   = 3'd0,
    U_BRANCH = 3'd1,
    U_LOAD   = 3'd2,
    U_STORE  = 3'd3,
    U_LDM    = 3'd4,
    U_STM    = 3'd5,
    U_RSV6   = 3'd6,
    U_RSV7   = 3'd7
  } unit_e;
endpackage

// File: rtl/cyc_acct_score.sv
// One-instruction scoreboard of registers written by a load.
module cyc_acct_score #(
  parameter int NREG = 16,
  localparam int IW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            is_load,
  input  logic [IW-1:0]   load_dst,
  output logic [NREG-1:0] active_mask
);
  logic [NREG-1:0] pend_mask;

  // Pending set starts empty for each instruction; a load adds its target.
  always_comb begin
    pend_mask = '0;
    if (is_load) pend_mask[load_dst] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    active_mask <= '0;
    else if (step) active_mask <= pend_mask;
  end

  // R6: after a non-load nothing is marked, after a load exactly one register
  p_clear_nonload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !is_load) |=> (active_mask == '0));
  p_single_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && is_load) |=> ($countones(active_mask) == 1));
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(active_mask));
endmodule

// File: rtl/cyc_acct_cost.sv
// Combinational cost of one instruction given the active load mask.
module cyc_acct_cost
  import cyc_acct_pkg::*;
#(
  parameter int NREG   = 16,
  parameter int BASE_W = 8,
  localparam int IW    = $clog2(NREG),
  localparam int CYC_W = BASE_W + 2
) (
  input  logic [2:0]       unit_kind,
  input  logic [BASE_W-1:0] base_cycles,
  input  logic [IW-1:0]    src_a_idx,
  input  logic             src_a_vld,
  input  logic [IW-1:0]    src_b_idx,
  input  logic             src_b_vld,
  input  logic             br_taken,
  input  logic             br_has_slot,
  input  logic [NREG-1:0]  active_mask,
  output logic [CYC_W-1:0] cycles,
  output logic [1:0]       ld_stall,
  output logic             br_stall,
  output logic             is_taken,
  output logic             is_untaken
);
  unit_e kind;
  logic  check_a, check_b, hit_a, hit_b, is_branch;

  always_comb begin
    kind = unit_e'(unit_kind);
    unique case (kind)
      U_EXEC, U_STORE:   begin check_a = 1'b1; check_b = 1'b1; end
      U_LOAD, U_BRANCH:  begin check_a = 1'b1; check_b = 1'b0; end
      default:           begin check_a = 1'b0; check_b = 1'b0; end
    endcase
    is_branch  = (kind == U_BRANCH);
    hit_a      = check_a && src_a_vld && active_mask[src_a_idx];
    hit_b      = check_b && src_b_vld && active_mask[src_b_idx];
    ld_stall   = {1'b0, hit_a} + {1'b0, hit_b};
    br_stall   = is_branch && br_taken && !br_has_slot;
    is_taken   = is_branch && br_taken;
    is_untaken = is_branch && !br_taken;
    cycles     = CYC_W'(base_cycles) + CYC_W'(ld_stall) + CYC_W'(br_stall);
  end
endmodule

// File: rtl/cyc_acct_satcnt.sv
// Saturating accumulator with clock enable.
module cyc_acct_satcnt #(
  parameter int W     = 32,
  parameter int INC_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [INC_W-1:0] inc,
  output logic [W-1:0]     count
);
  logic [W:0]   sum;
  logic [W-1:0] cnt_nxt;

  always_comb begin
    sum     = {1'b0, count} + (W+1)'(inc);
    cnt_nxt = sum[W] ? {W{1'b1}} : sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  count <= '0;
    else if (en) count <= cnt_nxt;
  end

  // R11: never wraps, and holds once at the top
  p_no_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (count >= $past(count)));
  p_hold_max_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (en && count == {W{1'b1}}) |=> (count == {W{1'b1}}));
endmodule

// File: rtl/cyc_acct_top.sv
module cyc_acct_top
  import cyc_acct_pkg::*;
#(
  parameter int NREG    = 16,
  parameter int BASE_W  = 8,
  parameter int COUNT_W = 32,
  localparam int IW     = $clog2(NREG),
  localparam int CYC_W  = BASE_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  input  logic [2:0]         unit_kind,
  input  logic [BASE_W-1:0]  base_cycles,
  input  logic [IW-1:0]      src_a_idx,
  input  logic               src_a_vld,
  input  logic [IW-1:0]      src_b_idx,
  input  logic               src_b_vld,
  input  logic [IW-1:0]      load_dst,
  input  logic               br_taken,
  input  logic               br_has_slot,
  output logic [CYC_W-1:0]   insn_cycles,
  output logic               insn_done,
  output logic [COUNT_W-1:0] total_cycles,
  output logic [COUNT_W-1:0] load_stall_cnt,
  output logic [COUNT_W-1:0] branch_stall_cnt,
  output logic [COUNT_W-1:0] taken_cnt,
  output logic [COUNT_W-1:0] untaken_cnt
);
  localparam int NCNT = 5;

  logic [NREG-1:0]  active_mask;
  logic [CYC_W-1:0] cyc_now;
  logic [1:0]       ld_stall;
  logic             br_stall, is_taken, is_untaken;
  logic [CYC_W-1:0] inc_v [NCNT];
  logic [COUNT_W-1:0] cnt_v [NCNT];

  cyc_acct_score #(.NREG(NREG)) u_score (
    .clk         (clk),
    .rst_n       (rst_n),
    .step        (instr_valid),
    .is_load     (unit_kind == U_LOAD),
    .load_dst    (load_dst),
    .active_mask (active_mask)
  );

  cyc_acct_cost #(.NREG(NREG), .BASE_W(BASE_W)) u_cost (
    .unit_kind   (unit_kind),
    .base_cycles (base_cycles),
    .src_a_idx   (src_a_idx),
    .src_a_vld   (src_a_vld),
    .src_b_idx   (src_b_idx),
    .src_b_vld   (src_b_vld),
    .br_taken    (br_taken),
    .br_has_slot (br_has_slot),
    .active_mask (active_mask),
    .cycles      (cyc_now),
    .ld_stall    (ld_stall),
    .br_stall    (br_stall),
    .is_taken    (is_taken),
    .is_untaken  (is_untaken)
  );

  always_comb begin
    inc_v[0] = cyc_now;
    inc_v[1] = CYC_W'(ld_stall);
    inc_v[2] = CYC_W'(br_stall);
    inc_v[3] = CYC_W'(is_taken);
    inc_v[4] = CYC_W'(is_untaken);
  end

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    cyc_acct_satcnt #(.W(COUNT_W), .INC_W(CYC_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (instr_valid),
      .inc   (inc_v[g]),
      .count (cnt_v[g])
    );
  end

  assign total_cycles     = cnt_v[0];
  assign load_stall_cnt   = cnt_v[1];
  assign branch_stall_cnt = cnt_v[2];
  assign taken_cnt        = cnt_v[3];
  assign untaken_cnt      = cnt_v[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      insn_cycles <= '0;
      insn_done   <= 1'b0;
    end else begin
      insn_done <= instr_valid;
      if (instr_valid) insn_cycles <= cyc_now;
    end
  end

  // R10: completion flag is a single-clock echo of the strobe
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |=> insn_done);
  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> !insn_done);
  // R9: multi-register kinds cost exactly their base
  p_multi_base_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && unit_kind[2]) |=> (insn_cycles == CYC_W'($past(base_cycles))));
  // R7: a branch with a delay slot never adds a branch stall
  p_slot_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && unit_kind == U_BRANCH && br_has_slot) |=> $stable(branch_stall_cnt));
  // R8: a taken branch below the top steps the taken counter by one
  p_taken_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && unit_kind == U_BRANCH && br_taken && taken_cnt != {COUNT_W{1'b1}})
    |=> (taken_cnt == $past(taken_cnt) + 1'b1));
endmodule

// File: tb/cyc_acct_top_test.sv
module cyc_acct_top_test;
  localparam int CW = 12;
  localparam longint CMAX = (64'd1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic instr_valid;
  logic [2:0] unit_kind;
  logic [7:0] base_cycles;
  logic [3:0] src_a_idx, src_b_idx, load_dst;
  logic src_a_vld, src_b_vld, br_taken, br_has_slot;
  logic [9:0] insn_cycles;
  logic insn_done;
  logic [CW-1:0] total_cycles, load_stall_cnt, branch_stall_cnt, taken_cnt, untaken_cnt;

  int n_checks = 0;
  int n_fail = 0;
  longint e_tot = 0, e_ls = 0, e_bs = 0, e_tk = 0, e_ut = 0;
  logic [15:0] e_mask = '0;

  always #2 clk = ~clk; // 250 MHz

  cyc_acct_top #(.COUNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .unit_kind(unit_kind),
    .base_cycles(base_cycles), .src_a_idx(src_a_idx), .src_a_vld(src_a_vld),
    .src_b_idx(src_b_idx), .src_b_vld(src_b_vld), .load_dst(load_dst),
    .br_taken(br_taken), .br_has_slot(br_has_slot), .insn_cycles(insn_cycles),
    .insn_done(insn_done), .total_cycles(total_cycles), .load_stall_cnt(load_stall_cnt),
    .branch_stall_cnt(branch_stall_cnt), .taken_cnt(taken_cnt), .untaken_cnt(untaken_cnt)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint sat(input longint v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  task automatic check_counters(input string tag);
    chk({tag, " total"}, total_cycles, e_tot);
    chk({tag, " load stalls"}, load_stall_cnt, e_ls);
    chk({tag, " branch stalls"}, branch_stall_cnt, e_bs);
    chk({tag, " taken"}, taken_cnt, e_tk);
    chk({tag, " untaken"}, untaken_cnt, e_ut);
  endtask

  // Drive one instruction at a falling edge, check the result one clock later.
  task automatic issue(input string tag, input int kind, input int base,
                       input int a, input bit av, input int b, input bit bv,
                       input int dst, input bit tk, input bit slot);
    bit ca, cb;
    int ls, bs;
    longint cyc;
    ca = (kind <= 3);
    cb = (kind == 0) || (kind == 3);
    ls = int'(ca && av && e_mask[a]) + int'(cb && bv && e_mask[b]);
    bs = int'(kind == 1 && tk && !slot);
    cyc = base + ls + bs;
    unit_kind = 3'(kind); base_cycles = 8'(base);
    src_a_idx = 4'(a); src_a_vld = av; src_b_idx = 4'(b); src_b_vld = bv;
    load_dst = 4'(dst); br_taken = tk; br_has_slot = slot;
    instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    e_tot = sat(e_tot + cyc);
    e_ls  = sat(e_ls + ls);
    e_bs  = sat(e_bs + bs);
    if (kind == 1) begin
      if (tk) e_tk = sat(e_tk + 1); else e_ut = sat(e_ut + 1);
    end
    e_mask = (kind == 2) ? (16'd1 << dst) : 16'd0;
    chk({tag, " R10 cycles"}, insn_cycles, cyc);
    chk({tag, " R10 done"}, insn_done, 1);
    check_counters(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; instr_valid = 1'b0; unit_kind = '0; base_cycles = '0;
    src_a_idx = '0; src_b_idx = '0; load_dst = '0;
    src_a_vld = 0; src_b_vld = 0; br_taken = 0; br_has_slot = 0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    chk("R1 insn_cycles", insn_cycles, 0);
    chk("R1 insn_done", insn_done, 0);
    check_counters("R1");
  endtask

  task automatic t_exec_store;
    issue("R3 load r3", 2, 2, 0, 0, 0, 0, 3, 0, 0);
    issue("R3 exec both r3", 0, 1, 3, 1, 3, 1, 0, 0, 0);
    issue("R3 load r5", 2, 2, 0, 0, 0, 0, 5, 0, 0);
    issue("R3 store b=r5", 3, 1, 1, 1, 5, 1, 0, 0, 0);
    issue("R3 load r8", 2, 2, 0, 0, 0, 0, 8, 0, 0);
    issue("R3 exec a=r8", 0, 3, 8, 1, 2, 1, 0, 0, 0);
    idle(1);
    chk("R10 done drops", insn_done, 0);
  endtask

  task automatic t_load_branch;
    issue("R4 load r7", 2, 2, 0, 0, 0, 0, 7, 0, 0);
    issue("R4 load b=r7 ignored", 2, 2, 2, 1, 7, 1, 9, 0, 0);
    issue("R4 branch a=r9", 1, 1, 9, 1, 9, 1, 0, 0, 1);
    issue("R4 load r1", 2, 2, 0, 0, 0, 0, 1, 0, 0);
    issue("R4 load a=r1", 2, 2, 1, 1, 0, 0, 4, 0, 0);
  endtask

  task automatic t_invalid;
    issue("R5 load r4", 2, 2, 0, 0, 0, 0, 4, 0, 0);
    issue("R5 exec invalid r4", 0, 1, 4, 0, 4, 0, 0, 0, 0);
    issue("R5 load r6", 2, 2, 0, 0, 0, 0, 6, 0, 0);
    issue("R5 store a invalid", 3, 1, 6, 0, 0, 1, 0, 0, 0);
  endtask

  task automatic t_window;
    issue("R6 load r6", 2, 2, 0, 0, 0, 0, 6, 0, 0);
    idle(5);
    issue("R6 exec after gap", 0, 1, 6, 1, 0, 0, 0, 0, 0);
    issue("R6 load r6 again", 2, 2, 0, 0, 0, 0, 6, 0, 0);
    issue("R6 exec unrelated", 0, 1, 0, 1, 1, 1, 0, 0, 0);
    issue("R6 exec stale r6", 0, 1, 6, 1, 6, 1, 0, 0, 0);
    issue("R6 load r2", 2, 2, 0, 0, 0, 0, 2, 0, 0);
    issue("R6 load r11 reads r11", 2, 2, 11, 1, 0, 0, 11, 0, 0);
    issue("R6 exec r2 not marked", 0, 1, 2, 1, 11, 1, 0, 0, 0);
  endtask

  task automatic t_branch;
    issue("R7 taken no slot", 1, 1, 0, 0, 0, 0, 0, 1, 0);
    issue("R7 taken slot", 1, 1, 0, 0, 0, 0, 0, 1, 1);
    issue("R8 untaken no slot", 1, 1, 0, 0, 0, 0, 0, 0, 0);
    issue("R8 untaken slot", 1, 1, 0, 0, 0, 0, 0, 0, 1);
    issue("R7 load r12", 2, 2, 0, 0, 0, 0, 12, 0, 0);
    issue("R7 taken no slot + hazard", 1, 1, 12, 1, 0, 0, 0, 1, 0);
  endtask

  task automatic t_multi;
    issue("R9 load r2", 2, 2, 0, 0, 0, 0, 2, 0, 0);
    issue("R9 ldm reads r2", 4, 5, 2, 1, 2, 1, 0, 1, 0);
    issue("R9 exec after ldm", 0, 1, 2, 1, 0, 0, 0, 0, 0);
    issue("R9 load r3", 2, 2, 0, 0, 0, 0, 3, 0, 0);
    issue("R9 stm reads r3", 5, 7, 3, 1, 3, 1, 0, 0, 0);
    issue("R2 load r1", 2, 2, 0, 0, 0, 0, 1, 0, 0);
    issue("R2 code6", 6, 3, 1, 1, 1, 1, 0, 1, 0);
    issue("R2 code7", 7, 4, 1, 1, 1, 1, 0, 1, 0);
  endtask

  task automatic t_saturate;
    for (int i = 0; i < 20; i++) issue("R11 fill", 0, 255, 0, 0, 0, 0, 0, 0, 0);
    chk("R11 total at max", total_cycles, CMAX);
    issue("R11 hold", 0, 9, 0, 0, 0, 0, 0, 0, 0);
    chk("R11 total held", total_cycles, CMAX);
  endtask

  initial begin
    t_reset();
    t_exec_store();
    t_load_branch();
    t_invalid();
    t_window();
    t_branch();
    t_multi();
    t_saturate();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule